// File: doc/BRIEF.md
# Packed Signed Multiply-Accumulate Unit

This block takes two 64-bit operands, each split into four signed 16-bit lanes. It multiplies the lanes that sit in the same position in the two operands, which gives four signed 32-bit products. It then adds the products in adjacent pairs, so two 32-bit sums come out packed in one 64-bit word. The upper operand lanes feed the upper half of the result and the lower lanes feed the lower half. The result is meant to overwrite the first operand in the surrounding datapath.

The unit is a fixed two-stage pipeline. The first register stage holds the four products and the second holds the two sums. A valid strobe travels alongside the data, and a new operand pair may enter on every clock. Each half-sum wraps modulo 2^32 and is never saturated. The unit reports no flags of any kind.

Top module: `pmac_unit`

## Requirements
- R1: Each product is the full signed 32-bit product of two 16-bit lanes in two's complement, so 8000H times 8000H gives 40000000H and FFFFH times FFFFH gives 00000001H.
- R2: `result[31:0]` equals (op_a[15:0]·op_b[15:0] + op_a[31:16]·op_b[31:16]) mod 2^32, with every factor signed.
- R3: `result[63:32]` equals (op_a[47:32]·op_b[47:32] + op_a[63:48]·op_b[63:48]) mod 2^32, with every factor signed.
- R4: A result half reads 80000000H only when all four 16-bit words feeding it are 8000H. In that case the sum wraps and is not clamped.
- R5: `out_valid` rises exactly two clock edges after the edge that samples `in_valid` high, and `result` belongs to that input pair.
- R6: The unit accepts a new operand pair on every cycle, so back-to-back inputs give back-to-back results in order.
- R7: A synchronous active-high `rst` clears both pipeline valid bits. `out_valid` is low on the cycle after a reset edge, even if `in_valid` was high while `rst` was asserted.
- R8: Cycles with `in_valid` low produce cycles with `out_valid` low, two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks an operand pair on `op_a` and `op_b` |
| op_a | input | 64 | First (destination) operand, four signed 16-bit lanes |
| op_b | input | 64 | Second (source) operand, four signed 16-bit lanes |
| out_valid | output | 1 | Marks a valid `result` |
| result | output | 64 | Two packed 32-bit pair sums |

## Verification
On every cycle, the assertions check the two-cycle valid latency, the clearing effect of reset, and both result halves against the operands captured two edges earlier. They also check that the value 80000000H appears in a half only when the inputs behind it were all 8000H. The bench scenarios are what show the sign-handling corner cases actually occurring: the all-8000H wrap, lanes of -1, mixed signs and zero lanes. The scenarios also show back-to-back streams with bubbles, and reset hitting a busy pipeline.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    localparam int LANE_W = 16;
    localparam int LANES  = 4;
    localparam int DATA_W = LANE_W * LANES;
    localparam int PROD_W = 2 * LANE_W;
    localparam int PAIRS  = LANES / 2;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic                  vld;
        prod_t [LANES-1:0]     prod;
    } mul_stage_t;

    typedef struct packed {
        logic                  vld;
        prod_t [PAIRS-1:0]     sum;
    } add_stage_t;

    // Sign-extend both factors to the product width; the truncated
    // product is then the exact two's-complement result.
    function automatic prod_t lane_mul(lane_t x, lane_t y);
        prod_t xe;
        prod_t ye;
        xe = {{LANE_W{x[LANE_W-1]}}, x};
        ye = {{LANE_W{y[LANE_W-1]}}, y};
        return xe * ye;
    endfunction
endpackage

// File: rtl/pmac_lane_mul.sv
module pmac_lane_mul
    import pmac_pkg::*;
(
    input  lane_t a,
    input  lane_t b,
    output prod_t p
);
    assign p = lane_mul(a, b);
endmodule

// File: rtl/pmac_mul_stage.sv
module pmac_mul_stage
    import pmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output mul_stage_t        q
);
    prod_t [LANES-1:0] prod_w;
    prod_t [LANES-1:0] prod_q;
    logic              vld_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmac_lane_mul u_mul (
            .a (op_a[g*LANE_W +: LANE_W]),
            .b (op_b[g*LANE_W +: LANE_W]),
            .p (prod_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        prod_q <= prod_w;
    end

    assign q.vld  = vld_q;
    assign q.prod = prod_q;
endmodule

// File: rtl/pmac_add_stage.sv
module pmac_add_stage
    import pmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mul_stage_t d,
    output add_stage_t q
);
    prod_t [PAIRS-1:0] sum_w;
    prod_t [PAIRS-1:0] sum_q;
    logic              vld_q;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign sum_w[k] = d.prod[2*k] + d.prod[2*k+1];
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= d.vld;
    end

    always_ff @(posedge clk) begin
        sum_q <= sum_w;
    end

    assign q.vld = vld_q;
    assign q.sum = sum_q;
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    mul_stage_t s1;
    add_stage_t s2;

    pmac_mul_stage u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .q        (s1)
    );

    pmac_add_stage u_add (
        .clk (clk),
        .rst (rst),
        .d   (s1),
        .q   (s2)
    );

    assign out_valid = s2.vld;
    assign result    = s2.sum;
endmodule

// File: rtl/pmac_unit_chk.sv
module pmac_unit_chk
    import pmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    function automatic logic [31:0] half_ref(logic [31:0] x, logic [31:0] y);
        logic signed [31:0] t0;
        logic signed [31:0] t1;
        t0 = 32'($signed(x[15:0])) * 32'($signed(y[15:0]));
        t1 = 32'($signed(x[31:16])) * 32'($signed(y[31:16]));
        return t0 + t1;
    endfunction

    assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    assert_issue_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$past(rst)) |-> ##2 out_valid);

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_low_half_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> result[31:0] == half_ref($past(op_a[31:0], 2), $past(op_b[31:0], 2)));

    assert_high_half_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> result[63:32] == half_ref($past(op_a[63:32], 2), $past(op_b[63:32], 2)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[31:0] == 32'h8000_0000) |->
            ($past(op_a[31:0], 2) == 32'h8000_8000 && $past(op_b[31:0], 2) == 32'h8000_8000));

    assert_no_overflow_hi_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[63:32] == 32'h8000_0000) |->
            ($past(op_a[63:32], 2) == 32'h8000_8000 && $past(op_b[63:32], 2) == 32'h8000_8000));
endmodule

bind pmac_unit pmac_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/test_pmac_unit.sv
module test_pmac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_a;
    logic [63:0] op_b;
    logic        out_valid;
    logic [63:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected pipeline: index 1 is what the outputs show at the next check
    bit          exp_v [2];
    logic [63:0] exp_d [2];
    string       exp_t [2];

    always #10 clk = ~clk;

    pmac_unit i_pmac_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] model_half(logic [31:0] x, logic [31:0] y);
        int lo;
        int hi;
        lo = int'($signed(x[15:0])) * int'($signed(y[15:0]));
        hi = int'($signed(x[31:16])) * int'($signed(y[31:16]));
        return 32'(lo + hi);
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b);
        return {model_half(a[63:32], b[63:32]), model_half(a[31:0], b[31:0])};
    endfunction

    task automatic check_out();
        n_cmp++;
        if (out_valid !== exp_v[1]) begin
            n_bad++;
            $display("FAIL R5 out_valid [%s]: actual %b expected %b", exp_t[1], out_valid, exp_v[1]);
        end
        if (exp_v[1]) begin
            n_cmp++;
            if (result[31:0] !== exp_d[1][31:0]) begin
                n_bad++;
                $display("FAIL R2 low half [%s]: actual %h expected %h",
                         exp_t[1], result[31:0], exp_d[1][31:0]);
            end
            n_cmp++;
            if (result[63:32] !== exp_d[1][63:32]) begin
                n_bad++;
                $display("FAIL R3 high half [%s]: actual %h expected %h",
                         exp_t[1], result[63:32], exp_d[1][63:32]);
            end
        end
    endtask

    task automatic step(bit r, bit v, logic [63:0] a, logic [63:0] b, string tag);
        @(negedge clk);
        check_out();
        exp_v[1] = exp_v[0];
        exp_d[1] = exp_d[0];
        exp_t[1] = exp_t[0];
        exp_v[0] = v;
        exp_d[0] = model(a, b);
        exp_t[0] = tag;
        if (r) begin
            exp_v[0] = 1'b0;
            exp_v[1] = 1'b0;
        end
        rst      = r;
        in_valid = v;
        op_a     = a;
        op_b     = b;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] ra;
        logic [63:0] rb;
        exp_v[0] = 1'b0; exp_v[1] = 1'b0;
        exp_d[0] = '0;   exp_d[1] = '0;
        exp_t[0] = "reset"; exp_t[1] = "reset";
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (2) @(negedge clk);
        // R7: reset state, then reset while in_valid is high
        step(1'b1, 1'b1, 64'h1, 64'h1, "R7 reset busy");
        step(1'b1, 1'b1, 64'h2, 64'h2, "R7 reset busy");
        step(1'b0, 1'b0, '0, '0, "R8 idle");
        step(1'b0, 1'b0, '0, '0, "R8 idle");
        // R1: 8000H squared in lane 0 only, FFFFH squared in lane 2 only
        step(1'b0, 1'b1, 64'h0000_FFFF_0000_8000, 64'h0000_FFFF_0000_8000, "R1 sign ext");
        // R4: all four words 8000H in both halves -> wrap to 80000000H
        step(1'b0, 1'b1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R4 wrap");
        // R4: three of four 8000H -> no wrap
        step(1'b0, 1'b1, 64'h8000_8000_8000_7FFF, 64'h8000_8000_8000_8000, "R4 near wrap");
        // mixed signs, all ones, zeros (R2, R3)
        step(1'b0, 1'b1, 64'h7FFF_8000_0003_FFFD, 64'h8000_7FFF_FFFB_0007, "mixed sign");
        step(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "all ones");
        step(1'b0, 1'b1, 64'h0, 64'h1234_8000_FFFF_7FFF, "zero lanes");
        step(1'b0, 1'b1, 64'h7FFF_7FFF_7FFF_7FFF, 64'h7FFF_7FFF_7FFF_7FFF, "max pos");
        // R8: bubbles
        step(1'b0, 1'b0, 64'hDEAD, 64'hBEEF, "R8 bubble");
        step(1'b0, 1'b1, 64'h0001_0002_0003_0004, 64'hFFFF_FFFE_FFFD_FFFC, "after bubble");
        step(1'b0, 1'b0, '0, '0, "R8 bubble");
        // R6: random stream with fixed seed, mostly back-to-back
        void'($urandom(32'd20240517));
        for (int i = 0; i < 400; i++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) ra[31:16] = 16'h8000;
            if ($urandom_range(0, 7) == 0) rb[63:48] = 16'hFFFF;
            step(1'b0, ($urandom_range(0, 9) != 0), ra, rb, "R6 random");
        end
        // R7: reset in the middle of a busy stream
        step(1'b0, 1'b1, 64'h5, 64'h6, "R7 pre");
        step(1'b1, 1'b1, 64'h7, 64'h8, "R7 mid reset");
        step(1'b0, 1'b1, 64'h9, 64'hA, "R7 post");
        repeat (3) step(1'b0, 1'b0, '0, '0, "drain");
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule